// File: doc/BRIEF.md
# Load-Adaptive VOQ Cell Scheduler

This block sits at one input port of a four-output cell switch that keeps a separate virtual output queue for each output. When a scheduling round begins, it reads the current cell count of every queue. It rates each queue as light, fair or heavy against two programmable fill thresholds. It then rates the port as a whole from how many queues fall into each class. The port rating selects how a round budget of up to eight cells is split among the queues.

A heavily loaded port puts most of the round into its fullest queue and gives a smaller share to the next fullest. A balanced port splits the round evenly between those two queues. A lightly loaded port takes a small share from every queue. No queue is ever granted more cells than it holds. The block turns the allocation into per-queue pop strobes, at most one per cycle. The queue storage beside it performs the pops, and the switching fabric downstream carries the cells.

Top module: `lavs_sched`

## Requirements
- R1: Queue i is heavy when occ_i*256 >= thr_hi*DEPTH. Otherwise it is light when occ_i*256 < thr_lo*DEPTH, and fair in the remaining cases. The thresholds are fractions of the queue depth in units of 1/256.
- R2: The port state is HEAVY (port_state = 2) when three or more of the four queues are heavy.
- R3: When fewer than three queues are heavy, the port state is LIGHT (port_state = 0) if three or more queues are light. In every other case it is FAIR (port_state = 1). The value 3 never appears.
- R4: In HEAVY, the fullest queue is allocated 6 cells, the second fullest 2 cells, and every other queue 0.
- R5: In FAIR, the fullest and second fullest queues are allocated 4 cells each, and every other queue 0.
- R6: In LIGHT, every queue is allocated 2 cells. A queue holding only 1 or 0 cells is allocated that number instead.
- R7: When queues have equal occupancy, the lower index ranks as fuller, both for the fullest and for the second fullest place.
- R8: Each queue's allocation is the smaller of its quota and its occupancy. Any shortfall is not passed on to another queue, and grant_cnt never exceeds 8.
- R9: Port state, allocations and grant_cnt are captured on the clock edge where round_start is high and busy is low. They then hold until the next round is captured. A round_start pulse while busy is high is ignored, and so are occupancy changes during a round.
- R10: Pops leave one per cycle, starting in the cycle after the capture edge. Each pop goes to the lowest-index queue with allocation left. Busy is high exactly while allocation remains, so a round with nothing to pop never raises busy.
- R11: While reset is held (active-low rst_n), busy, pop and grant_cnt are 0 and port_state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| round_start | input | 1 | Starts a scheduling round when idle |
| thr_lo | input | FRAC_W | Light threshold, as a fraction of depth in 1/256 units |
| thr_hi | input | FRAC_W | Heavy threshold, as a fraction of depth in 1/256 units |
| occ_flat | input | NQ*clog2(DEPTH+1) | Cell counts of the queues, queue 0 in the least significant field |
| pop | output | NQ | One-hot pop strobe per queue |
| busy | output | 1 | High while the current round still has cells to pop |
| grant_cnt | output | clog2(9) | Total cells allocated in the latest captured round |
| port_state | output | 2 | Port rating: 0 light, 1 fair, 2 heavy |

## Verification
The capture edge is the rising edge on which round_start is seen high. Port state, grant count and busy become valid one register stage later, and the bench reads them on the falling edge that immediately follows. The first pop is visible at that same falling edge, and the n-th pop appears n-1 cycles later. Busy must read low exactly the number of granted cycles after the first sample. The driver queues the hand-derived order of pop indices before it raises the strobe. A monitor running on every falling edge consumes one entry per pop it sees, so an extra, missing or misplaced pop is caught in the cycle where it occurs.

// File: rtl/lavs_pkg.sv
package lavs_pkg;

    typedef enum logic [1:0] {
        LVL_LIGHT = 2'd0,
        LVL_FAIR  = 2'd1,
        LVL_HEAVY = 2'd2
    } level_e;

    localparam int unsigned ROUND_CELLS = 8;
    localparam int unsigned HEAVY_MAJOR = 6;
    localparam int unsigned HEAVY_MINOR = 2;
    localparam int unsigned FAIR_SHARE  = 4;
    localparam int unsigned LIGHT_SHARE = 2;

endpackage

// File: rtl/lavs_level.sv
module lavs_level
    import lavs_pkg::*;
#(
    parameter int unsigned OCC_W  = 6,
    parameter int unsigned FRAC_W = 8,
    parameter int unsigned DEPTH  = 32
) (
    input  logic [OCC_W-1:0]  occ,
    input  logic [FRAC_W-1:0] thr_lo,
    input  logic [FRAC_W-1:0] thr_hi,
    output level_e            level
);
    localparam int unsigned PW = OCC_W + FRAC_W + 1;

    logic [PW-1:0] occ_scaled;
    logic [PW-1:0] lo_mark;
    logic [PW-1:0] hi_mark;

    // Fill ratio compared by cross-multiplying with the depth; no divider.
    always_comb begin
        occ_scaled = PW'(occ) << FRAC_W;
        lo_mark    = PW'(thr_lo) * PW'(DEPTH);
        hi_mark    = PW'(thr_hi) * PW'(DEPTH);
        if (occ_scaled >= hi_mark) begin
            level = LVL_HEAVY;
        end else if (occ_scaled < lo_mark) begin
            level = LVL_LIGHT;
        end else begin
            level = LVL_FAIR;
        end
    end

endmodule

// File: rtl/lavs_rank.sv
module lavs_rank #(
    parameter int unsigned NQ    = 4,
    parameter int unsigned OCC_W = 6,
    parameter int unsigned IW    = 2
) (
    input  logic [NQ-1:0][OCC_W-1:0] occ_a,
    output logic [IW-1:0]            first,
    output logic [IW-1:0]            second
);
    // Ascending scan with strict compare: equal counts keep the lower index.
    always_comb begin
        first = '0;
        for (int i = 1; i < NQ; i++) begin
            if (occ_a[i] > occ_a[first]) begin
                first = IW'(i);
            end
        end
        second = (first == '0) ? IW'(1) : '0;
        for (int i = 0; i < NQ; i++) begin
            if (IW'(i) != first && occ_a[i] > occ_a[second]) begin
                second = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lavs_quota.sv
module lavs_quota
    import lavs_pkg::*;
#(
    parameter int unsigned NQ    = 4,
    parameter int unsigned OCC_W = 6,
    parameter int unsigned IW    = 2,
    parameter int unsigned CW    = 4
) (
    input  level_e                   state,
    input  logic [IW-1:0]            first,
    input  logic [IW-1:0]            second,
    input  logic [NQ-1:0][OCC_W-1:0] occ_a,
    output logic [NQ-1:0][CW-1:0]    quota,
    output logic [CW-1:0]            total
);
    logic [CW-1:0] base;

    always_comb begin
        total = '0;
        quota = '0;
        for (int i = 0; i < NQ; i++) begin
            base = '0;
            unique case (state)
                LVL_HEAVY: begin
                    if (IW'(i) == first) begin
                        base = CW'(HEAVY_MAJOR);
                    end else if (IW'(i) == second) begin
                        base = CW'(HEAVY_MINOR);
                    end
                end
                LVL_FAIR: begin
                    if (IW'(i) == first || IW'(i) == second) begin
                        base = CW'(FAIR_SHARE);
                    end
                end
                default: begin
                    base = CW'(LIGHT_SHARE);
                end
            endcase
            // Cap at what the queue holds; shortfall stays unused.
            if (32'(occ_a[i]) < 32'(base)) begin
                quota[i] = CW'(occ_a[i]);
            end else begin
                quota[i] = base;
            end
            total = total + quota[i];
        end
    end

endmodule

// File: rtl/lavs_sched.sv
module lavs_sched
    import lavs_pkg::*;
#(
    parameter int unsigned NQ     = 4,
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned FRAC_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               round_start,
    input  logic [FRAC_W-1:0]                  thr_lo,
    input  logic [FRAC_W-1:0]                  thr_hi,
    input  logic [NQ*$clog2(DEPTH+1)-1:0]      occ_flat,
    output logic [NQ-1:0]                      pop,
    output logic                               busy,
    output logic [$clog2(ROUND_CELLS+1)-1:0]   grant_cnt,
    output logic [1:0]                         port_state
);
    localparam int unsigned OCC_W = $clog2(DEPTH + 1);
    localparam int unsigned IW    = $clog2(NQ);
    localparam int unsigned CW    = $clog2(ROUND_CELLS + 1);
    localparam int unsigned KW    = $clog2(NQ + 1);
    localparam int unsigned MAJ   = NQ - 1;

    typedef struct packed {
        logic                 busy;
        level_e               state;
        logic [NQ-1:0][CW-1:0] left;
        logic [CW-1:0]        gcnt;
    } regs_t;

    regs_t q, d;

    logic [NQ-1:0][OCC_W-1:0] occ_a;
    level_e                   lvl [NQ];
    logic [KW-1:0]            heavy_cnt;
    logic [KW-1:0]            light_cnt;
    level_e                   port_state_c;
    logic [IW-1:0]            rank_first;
    logic [IW-1:0]            rank_second;
    logic [NQ-1:0][CW-1:0]    quota;
    logic [CW-1:0]            total;
    logic [NQ-1:0]            pop_c;
    logic                     found;

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        assign occ_a[g] = occ_flat[g*OCC_W +: OCC_W];

        lavs_level #(
            .OCC_W (OCC_W),
            .FRAC_W(FRAC_W),
            .DEPTH (DEPTH)
        ) u_level (
            .occ   (occ_a[g]),
            .thr_lo(thr_lo),
            .thr_hi(thr_hi),
            .level (lvl[g])
        );
    end

    always_comb begin
        heavy_cnt = '0;
        light_cnt = '0;
        for (int i = 0; i < NQ; i++) begin
            if (lvl[i] == LVL_HEAVY) heavy_cnt = heavy_cnt + 1'b1;
            if (lvl[i] == LVL_LIGHT) light_cnt = light_cnt + 1'b1;
        end
        if (heavy_cnt >= KW'(MAJ)) begin
            port_state_c = LVL_HEAVY;
        end else if (light_cnt >= KW'(MAJ)) begin
            port_state_c = LVL_LIGHT;
        end else begin
            port_state_c = LVL_FAIR;
        end
    end

    lavs_rank #(
        .NQ   (NQ),
        .OCC_W(OCC_W),
        .IW   (IW)
    ) u_rank (
        .occ_a (occ_a),
        .first (rank_first),
        .second(rank_second)
    );

    lavs_quota #(
        .NQ   (NQ),
        .OCC_W(OCC_W),
        .IW   (IW),
        .CW   (CW)
    ) u_quota (
        .state (port_state_c),
        .first (rank_first),
        .second(rank_second),
        .occ_a (occ_a),
        .quota (quota),
        .total (total)
    );

    // Lowest-index queue with allocation left is served next.
    always_comb begin
        pop_c = '0;
        found = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            if (!found && q.left[i] != '0) begin
                pop_c[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        d = q;
        if (q.busy) begin
            for (int i = 0; i < NQ; i++) begin
                if (pop_c[i]) d.left[i] = q.left[i] - 1'b1;
            end
            d.busy = |d.left;
        end else if (round_start) begin
            d.state = port_state_c;
            d.left  = quota;
            d.gcnt  = total;
            d.busy  = (total != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pop        = q.busy ? pop_c : '0;
    assign busy       = q.busy;
    assign grant_cnt  = q.gcnt;
    assign port_state = q.state;

    AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop)); // R10
    AST_POP_IN_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (pop != '0) |-> busy); // R10
    AST_ROUND_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(round_start)); // R9
    AST_ROUND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(port_state) && $stable(grant_cnt))); // R9
    AST_GRANT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        grant_cnt <= CW'(ROUND_CELLS)); // R8
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        port_state != 2'd3); // R3

endmodule

// File: tb/lavs_sched_tb.sv
`timescale 1ns/1ps
module lavs_sched_tb;
    localparam int NQ = 4;
    localparam int DEPTH = 32;
    localparam int FRAC_W = 8;
    localparam int OCC_W = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 round_start = 1'b0;
    logic [FRAC_W-1:0]    thr_lo = 8'd64;
    logic [FRAC_W-1:0]    thr_hi = 8'd192;
    logic [NQ*OCC_W-1:0]  occ_flat = '0;
    logic [NQ-1:0]        pop;
    logic                 busy;
    logic [3:0]           grant_cnt;
    logic [1:0]           port_state;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    int mon_e;
    bit done = 0;

    always #2 clk = ~clk;

    lavs_sched #(.NQ(NQ), .DEPTH(DEPTH), .FRAC_W(FRAC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .round_start(round_start),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .occ_flat(occ_flat),
        .pop(pop), .busy(busy), .grant_cnt(grant_cnt), .port_state(port_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_occ(input int o0, o1, o2, o3);
        occ_flat = {6'(o3), 6'(o2), 6'(o1), 6'(o0)};
    endtask

    task automatic push_seq(input int q0, q1, q2, q3);
        for (int k = 0; k < q0; k++) exp_q.push_back(0);
        for (int k = 0; k < q1; k++) exp_q.push_back(1);
        for (int k = 0; k < q2; k++) exp_q.push_back(2);
        for (int k = 0; k < q3; k++) exp_q.push_back(3);
    endtask

    // Monitor: each pop must match the next expected queue index (R10).
    always @(negedge clk) begin
        if (rst_n && pop != '0) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected pop", int'(pop), 0);
            end else begin
                mon_e = exp_q.pop_front();
                chk(pop == 4'(1 << mon_e), "R10 pop order", int'(pop), 1 << mon_e);
            end
        end
    end

    task automatic run_round(input string tag, input int o0, o1, o2, o3,
                             input int es, input int q0, q1, q2, q3);
        int tot;
        tot = q0 + q1 + q2 + q3;
        @(negedge clk);
        set_occ(o0, o1, o2, o3);
        push_seq(q0, q1, q2, q3);
        round_start = 1'b1;
        @(negedge clk);
        round_start = 1'b0;
        chk(port_state == 2'(es), {tag, " port state"}, port_state, es);
        chk(grant_cnt == 4'(tot), {tag, " grant count"}, grant_cnt, tot);
        chk(busy == (tot != 0), "R10 busy after capture", busy, tot != 0);
        repeat (tot) @(negedge clk);
        chk(busy == 1'b0, "R10 busy ends with allocation", busy, 0);
        chk(exp_q.size() == 0, {tag, " pops outstanding"}, exp_q.size(), 0);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R11 busy in reset", busy, 0);
        chk(pop == '0, "R11 pop in reset", pop, 0);
        chk(grant_cnt == '0, "R11 grant in reset", grant_cnt, 0);
        chk(port_state == 2'd0, "R11 state in reset", port_state, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && pop == '0, "R11 idle after reset", busy, 0);

        // R2 R4: three heavy queues, fullest q0, second q2
        run_round("R2 R4", 30, 26, 28, 5, 2, 6, 0, 2, 0);
        // R3 R5: one light queue, so FAIR; fullest q1, second q2
        run_round("R3 R5", 10, 20, 12, 3, 1, 0, 4, 4, 0);
        // R3 R6: all light, short queues send what they hold
        run_round("R3 R6", 1, 0, 5, 7, 0, 1, 0, 2, 2);
        // R7: equal counts rank lower index first
        run_round("R7 fair tie", 15, 15, 15, 2, 1, 4, 4, 0, 0);
        run_round("R7 heavy tie", 28, 30, 30, 30, 2, 0, 6, 2, 0);
        // R1: threshold boundaries (24 is heavy, 8 is not light)
        run_round("R1 heavy edge", 24, 24, 24, 7, 2, 6, 2, 0, 0);
        run_round("R1 below heavy", 23, 24, 24, 7, 1, 0, 4, 4, 0);
        run_round("R1 light edge", 8, 7, 7, 7, 0, 2, 2, 2, 2);
        run_round("R1 two light", 8, 8, 7, 7, 1, 4, 4, 0, 0);
        // R8: caps without redistribution; q2 holds a cell but gets none
        thr_lo = 8'd0;
        thr_hi = 8'd255;
        run_round("R8", 3, 2, 1, 0, 1, 3, 2, 0, 0);
        thr_lo = 8'd64;
        thr_hi = 8'd192;
        // R6 R10: empty queues give an empty round, busy never rises
        run_round("R6 R10 empty", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R9: strobe and occupancy change mid-round are ignored
        @(negedge clk);
        set_occ(30, 26, 28, 5);
        push_seq(6, 0, 2, 0);
        round_start = 1'b1;
        @(negedge clk);
        round_start = 1'b0;
        chk(port_state == 2'd2, "R9 captured state", port_state, 2);
        @(negedge clk);
        @(negedge clk);
        set_occ(0, 0, 0, 0);
        round_start = 1'b1;
        @(negedge clk);
        round_start = 1'b0;
        chk(port_state == 2'd2, "R9 state held", port_state, 2);
        chk(grant_cnt == 4'd8, "R9 grant held", grant_cnt, 8);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R9 round ends on schedule", busy, 0);
        chk(exp_q.size() == 0, "R9 all pops seen", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9 ignored strobe starts nothing", busy, 0);
        chk(grant_cnt == 4'd8, "R9 grant kept after round", grant_cnt, 8);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule